// File: doc/BRIEF.md
# Filtered Trigger Pulse Stretcher

This block turns an asynchronous, active-high trigger into an active-high output pulse of fixed width. It runs on one clock and has an active-low synchronous reset. While the block is armed, the raw trigger goes straight to the output, so the leading edge arrives with no clock latency. In parallel, the trigger is synchronized and passed through a shift-register glitch filter. When every filter stage holds a one, a counter takes over the output and holds it high for exactly `PULSE_W` clock periods.

Once the counted pulse has started, a latched rejection state keeps the output under counter control. An input that lasts longer than the programmed width cannot extend the output past the count. The block re-arms only after the synchronized trigger has returned low. The trigger, the output and the reset are plain level pins with no handshake. `PULSE_W`, `FILT_LEN` and `SYNC_STAGES` are fixed when the block is built.

Timing convention: S = `SYNC_STAGES`, F = `FILT_LEN` and W = `PULSE_W`. Edge 1 is the first rising clock edge after the trigger rises. Period n is the interval between edge n and edge n+1, and period 0 is the interval before edge 1.

Top module: `trig_stretch`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is low from the first clock edge of reset onward. After reset is released with the trigger low, the block is armed and `pulse_o` is low.
- R2: While the block is armed and no counted pulse is active, `pulse_o` equals `trig_i` combinationally, in the same period in which the trigger changes.
- R3: A trigger held high for fewer than F consecutive clock edges produces no counted pulse. The output only follows the raw trigger and goes low when the trigger goes low.
- R4: A trigger held high for at least F edges starts a counted pulse. `pulse_o` is high in periods S+F+1 through S+F+W inclusive, and exactly W such periods follow.
- R5: After the counted pulse ends, `pulse_o` stays low while the trigger remains high, however long the trigger lasts. Before period S+F+1, the output is the raw trigger.
- R6: A new counted pulse can start only after the synchronized trigger has been seen low. After the trigger has been low for at least S+F+2 periods, a fresh trigger behaves exactly as in R2 to R5.
- R7: The filter requires consecutive ones. A trigger that goes high for F-1 edges, drops for one edge and repeats never starts a counted pulse.
- R8: A reset during a counted pulse drops `pulse_o` at the next clock edge. After release, the block behaves as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Asynchronous trigger, active high |
| pulse_o | output | 1 | Stretched pulse, active high |

## Verification
The bench sweeps the trigger length from one cycle up to well beyond S+F+W. Each sweep checks `pulse_o` in every period against a closed-form prediction, so an off-by-one in the synchronizer depth, the filter fill or the counter terminal value moves the edges and is caught. The trigger length of exactly F is the case most likely to go wrong: the raw output drops and the counted pulse must still appear. A filter that does not flush on a zero either misses that pulse or fires on the broken F-1 pattern. A rejection state that clears too early or never latches would re-fire or stretch the output while a long trigger stays high. The reset taken mid-pulse exposes a counter that is not cleared.

// File: rtl/trig_stretch_pkg.sv
package trig_stretch_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_COUNT = 2'd1,
    ST_BLOCK = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic full_o
);
  // Each stage only holds a one if the input is still high: a zero flushes the chain.
  logic [LEN-1:0] taps;

  genvar g;
  generate
    for (g = 0; g < LEN; g++) begin : g_tap
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) taps[0] <= 1'b0;
          else        taps[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) taps[g] <= 1'b0;
          else        taps[g] <= d_i & taps[g-1];
        end
      end
    end
  endgenerate

  assign full_o = &taps;
endmodule

// File: rtl/stretch_fsm.sv
module stretch_fsm
  import trig_stretch_pkg::*;
#(
  parameter int PULSE_W = 125
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           full_i,
  input  logic           trig_s_i,
  output stretch_state_e st_o
);
  localparam int CNT_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_W - 1);

  stretch_state_e st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_ARMED;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_ARMED: begin
          cnt_q <= '0;
          if (full_i) st_q <= ST_COUNT;
        end
        ST_COUNT: begin
          if (cnt_q == LAST) begin
            st_q  <= ST_BLOCK;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_BLOCK: begin
          if (!trig_s_i) st_q <= ST_ARMED;
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/trig_stretch.sv
module trig_stretch
  import trig_stretch_pkg::*;
#(
  parameter int PULSE_W     = 125,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic           trig_s;
  logic           filt_full;
  stretch_state_e st_q;
  logic           live_q;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (trig_i),
    .q_o   (trig_s)
  );

  glitch_filter #(.LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (trig_s),
    .full_o (filt_full)
  );

  stretch_fsm #(.PULSE_W(PULSE_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_i   (filt_full),
    .trig_s_i (trig_s),
    .st_o     (st_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // Mux select is the registered state: raw trigger while armed, counter pulse otherwise.
  always_comb begin
    if (!live_q)                pulse_o = 1'b0;
    else if (st_q == ST_ARMED)  pulse_o = trig_i;
    else                        pulse_o = (st_q == ST_COUNT);
  end
endmodule

// File: rtl/trig_stretch_chk.sv
module trig_stretch_chk
  import trig_stretch_pkg::*;
#(
  parameter int PULSE_W = 125
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig_i,
  input logic           pulse_o,
  input logic           trig_s,
  input logic           filt_full,
  input stretch_state_e st_q
);
  localparam int RUN_W = $clog2(PULSE_W + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= '0;
    else if (st_q == ST_COUNT) run_q <= run_q + 1'b1;
    else                       run_q <= '0;
  end

  assert_raw_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && $past(rst_n)) |-> (pulse_o == trig_i));

  assert_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && !filt_full) |=> (st_q == ST_ARMED));

  assert_count_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT) |-> pulse_o);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT) |-> (run_q < RUN_W'(PULSE_W)));

  assert_block_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLOCK) |-> !pulse_o);

  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLOCK && trig_s) |=> (st_q == ST_BLOCK));
endmodule

bind trig_stretch trig_stretch_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_i    (trig_i),
  .pulse_o   (pulse_o),
  .trig_s    (trig_s),
  .filt_full (filt_full),
  .st_q      (st_q)
);

// File: tb/trig_stretch_tb.sv
module trig_stretch_tb;
  localparam int W  = 6;
  localparam int F  = 4;
  localparam int S  = 2;
  localparam int P0 = S + F + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic pulse;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trig_stretch #(.PULSE_W(W), .FILT_LEN(F), .SYNC_STAGES(S)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig),
    .pulse_o (pulse)
  );

  task automatic check(input logic exp, input string req, input int k);
    total++;
    if (pulse !== exp) begin
      bad++;
      $display("FAIL %s period=%0d actual=%b expected=%b", req, k, pulse, exp);
    end
  endtask

  function automatic logic model(input int len, input int k);
    if (len >= F && k >= P0) return (k < P0 + W);
    return (k < len);
  endfunction

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig = 1'b0;
      #1 check(1'b0, req, i);
    end
  endtask

  task automatic trial(input int len);
    string req;
    if (len < F)             req = "R3";
    else if (len > P0 + W)   req = "R5";
    else                     req = "R4";
    for (int k = 0; k < len + P0 + W + 4; k++) begin
      @(negedge clk);
      trig = (k < len);
      #1;
      if (k == 0) check(1'b1, "R2", k);
      else        check(model(len, k), req, k);
    end
    quiet(S + F + 2, "R6");
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      #1 check(1'b0, "R1", 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(1'b0, "R1", 0);
    quiet(3, "R1");

    // R2..R5 sweep of trigger length
    for (int len = 1; len <= P0 + W + 8; len++) trial(len);

    // R6: back-to-back full triggers each fire again
    trial(F);
    trial(F + 1);

    // R7: broken pattern never reaches a full filter, output mirrors the trigger
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < F; k++) begin
        @(negedge clk);
        trig = (k < F - 1);
        #1 check(trig, "R7", k);
      end
    end
    quiet(P0 + W + 2, "R7");

    // R8: reset in the middle of the counted pulse
    for (int k = 0; k < P0 + 2; k++) begin
      @(negedge clk);
      trig = 1'b1;
    end
    #1 check(1'b1, "R4", P0 + 2);
    @(negedge clk);
    rst_n = 1'b0;
    trig  = 1'b0;
    @(negedge clk);
    #1 check(1'b0, "R8", 0);
    @(negedge clk);
    #1 check(1'b0, "R8", 1);
    rst_n = 1'b1;
    quiet(S + F + 2, "R8");
    trial(F + 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule